// File: doc/BRIEF.md
# Accumulator-Clocked Noise Generator

This block produces the pseudo-random noise waveform of one synthesizer voice. It contains a 23-bit linear feedback shift register. The register advances once each time bit 19 of the voice's phase accumulator rises from 0 to 1, so the noise pitch follows the oscillator frequency.

The accumulator lives outside the block. It supplies the value of bit 19 from the previous cycle and the value from the current cycle. A hold input corresponds to the oscillator test bit and freezes the register.

Eight non-adjacent register bits are gathered into the upper byte of a 12-bit noise sample, and the four lowest sample bits are zero. The same eight bits are also presented as a byte for readback.

Top module: `noise_lfsr`

## Requirements
- R1: While reset is asserted and after it is released, the register holds the seed 0x7FFFF8. With that seed the tap byte reads 0xFE and the noise sample reads 0xFE0.
- R2: The register steps exactly once on a clock edge where `acc_b19_prev` is 0, `acc_b19_now` is 1 and `hold` is 0.
- R3: For any other combination of `acc_b19_prev` and `acc_b19_now` (00, 11, 10), the register keeps its value.
- R4: While `hold` is 1 the register keeps its value, even on an accumulator bit-19 rising edge.
- R5: A step shifts the register left by one and discards the old bit 22. The new bit 0 is old bit 22 XOR old bit 17.
- R6: Noise sample bits 11 down to 4 are register bits 22, 20, 16, 13, 11, 7, 4 and 2, in that order.
- R7: Noise sample bits 3 to 0 are always zero.
- R8: `tap_byte` always equals noise sample bits 11 to 4.
- R9: The register never reaches the all-zero state. Over a long run of steps, the tap byte is never stuck at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the seed |
| acc_b19_prev | input | 1 | Accumulator bit 19 in the previous cycle |
| acc_b19_now | input | 1 | Accumulator bit 19 in the current cycle |
| hold | input | 1 | Test bit; freezes the register while high |
| noise_out | output | 12 | Noise sample; upper byte is the taps, low nibble is zero |
| tap_byte | output | 8 | Readback of the eight tapped register bits |

## Verification
The bench mixes every combination of the two bit-19 samples with the hold bit. This catches a design that steps on a level or a falling edge rather than a rising edge, which would drift away from the model on the first 11 or 10 pattern. It also catches a design that ignores hold, which would step while the test bit is high.

A run of several thousand consecutive steps compares the tap byte against a bench-side register model. A wrong feedback tap or a swapped output bit soon shows up as a mismatched byte, and a lost seed or lock-up shows up as a byte stuck at zero. The reset value is checked directly against the seed-derived 0xFE0.

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int              LEN   = 23,
  parameter logic [LEN-1:0]  SEED  = 23'h7FFFF8,
  parameter int              FB_A  = 22,
  parameter int              FB_B  = 17,
  parameter int              OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_b19_prev,
  input  logic             acc_b19_now,
  input  logic             hold,
  output logic [OUT_W-1:0] noise_out,
  output logic [7:0]       tap_byte
);
  localparam int TAPS = 8;
  localparam int PAD  = OUT_W - TAPS;
  localparam int TAP_POS [TAPS] = '{22, 20, 16, 13, 11, 7, 4, 2};

  logic [LEN-1:0] lfsr;
  logic           step;
  logic           fb;

  assign step = ~acc_b19_prev & acc_b19_now & ~hold;
  assign fb   = lfsr[FB_A] ^ lfsr[FB_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lfsr <= SEED;
    else if (step) lfsr <= {lfsr[LEN-2:0], fb};
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_byte[TAPS-1-i] = lfsr[TAP_POS[i]];
  end

  assign noise_out = {tap_byte, {PAD{1'b0}}};

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(lfsr)); // R4
  AST_NO_EDGE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!acc_b19_prev && acc_b19_now) |=> $stable(lfsr)); // R3
  AST_STEP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_b19_prev && acc_b19_now && !hold) |=> lfsr[LEN-1:1] == $past(lfsr[LEN-2:0])); // R5
  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R9
endmodule

// File: tb/noise_lfsr_tb.sv
module noise_lfsr_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        prev = 0, now = 0, hold = 0;
  logic [11:0] noise_out;
  logic [7:0]  tap_byte;
  logic [22:0] model;
  int          vecs = 0, errs = 0, cyc = 0, zrun = 0;

  always #10 clk = ~clk;

  noise_lfsr u_dut (
    .clk(clk), .rst_n(rst_n), .acc_b19_prev(prev), .acc_b19_now(now),
    .hold(hold), .noise_out(noise_out), .tap_byte(tap_byte)
  );

  function automatic logic [7:0] taps_of(logic [22:0] r);
    return {r[22], r[20], r[16], r[13], r[11], r[7], r[4], r[2]};
  endfunction

  task automatic check(string req);
    logic [7:0] eb;
    eb = taps_of(model);
    vecs++;
    if (noise_out !== {eb, 4'h0}) begin
      errs++;
      $display("FAIL %s: noise_out=%h expected %h", req, noise_out, {eb, 4'h0});
    end
    vecs++;
    if (tap_byte !== noise_out[11:4]) begin
      errs++;
      $display("FAIL R8: tap_byte=%h expected %h", tap_byte, noise_out[11:4]);
    end
    vecs++;
    if (noise_out[3:0] !== 4'h0) begin
      errs++;
      $display("FAIL R7: low nibble=%h expected 0", noise_out[3:0]);
    end
  endtask

  task automatic apply(logic p, logic n, logic h);
    string req;
    prev = p; now = n; hold = h;
    @(posedge clk);
    if (!p && n && !h) begin
      model = {model[21:0], model[22] ^ model[17]};
      req = "R2/R5/R6";
    end else if (h) req = "R4";
    else req = "R3";
    @(negedge clk);
    check(req);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog: cycles=%0d expected <150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    model = 23'h7FFFF8;
    repeat (3) @(negedge clk);
    check("R1");
    vecs++;
    if (noise_out !== 12'hFE0) begin
      errs++;
      $display("FAIL R1: noise_out=%h expected fe0", noise_out);
    end
    rst_n = 1;
    @(negedge clk);
    check("R1");
    for (int k = 0; k < 4000; k++) begin
      for (int c = 0; c < 8; c++) apply(c[2], c[1], c[0]);
    end
    for (int k = 0; k < 6000; k++) begin
      apply(1'b0, 1'b1, 1'b0);
      if (tap_byte == 8'h00) zrun++; else zrun = 0;
      vecs++;
      if (zrun > 30) begin
        errs++;
        $display("FAIL R9: tap_byte zero run=%0d expected <=30", zrun);
        zrun = 0;
      end
    end
    for (int k = 0; k < 5000; k++) begin
      logic [2:0] r;
      r = 3'($urandom);
      apply(r[2], r[1], r[0]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule